// File: doc/BRIEF.md
# Zero-Cross Gated Stereo Volume and Mute Controller

This block is the digital volume stage of one stereo television audio path. It picks one of several stereo sources, scales the chosen left and right samples by a gain looked up from a combined coarse (8 dB per step) and fine (1 dB per step) attenuation code, and drives left, right and mono outputs. The mono output is the average of the two scaled channels.

Volume and mute settings arrive with a one-cycle write strobe. When zero-cross gating is off, a write takes effect at once. When it is on, the new setting is parked. It is applied only after both channels have crossed zero, which avoids audible clicks. A sticky status flag tells a controller whether the parked setting has been applied. A hardware mute input silences all three outputs whatever the stored settings are.

Top module: `zc_volume_ctrl`

## Requirements
- R1: After reset the outputs are zero, `zc_stat_o` is 0, source code 0 is selected, attenuation is 0 dB and mute is off.
- R2: The attenuation in dB is n = 8*coarse + fine (0 to 63). The gain is g(0)=32767 and g(k)=floor(g(k-1)*29205/32768). Each output is floor(sample*g(n)/32768), saturated to 16-bit signed. An input sample appears scaled on the output two clock edges after it is presented.
- R3: Source code k from 0 to 4 selects bits [16k+15:16k] of `src_l_i` and `src_r_i`. Codes 5 to 7 give zero outputs. The source code is taken at every write, with no gating.
- R4: A write with `zc_en_i`=0 applies coarse, fine and mute at that edge, and sets `zc_stat_o` to 1.
- R5: A write with `zc_en_i`=1 clears `zc_stat_o` and holds the new settings pending. The previously applied settings keep acting until commit.
- R6: A channel has crossed zero when the sign bit of two consecutive selected samples differs, or when a selected sample equals zero. A pending setting commits at the edge where both channels have crossed since the write, and `zc_stat_o` then becomes 1.
- R7: Mute and un-mute are subject to the same gating: with `zc_en_i`=1, both wait for the crossing condition of R6.
- R8: `hw_mute_i`=1 forces left, right and mono outputs to zero from the next edge. Stored settings are not altered, so the volume resumes when the input is released.
- R9: The mono output equals floor((left+right)/2) of the current outputs, so it follows volume and mute.
- R10: A write made while a setting is pending replaces it and restarts crossing tracking. A crossing seen before the new write does not count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one sample per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_l_i | input | 80 | Left samples of five sources, source k in bits [16k+15:16k] |
| src_r_i | input | 80 | Right samples of five sources, same layout |
| wr_i | input | 1 | Write strobe for the setting inputs |
| src_sel_i | input | 3 | Source code (0 to 4 select, 5 to 7 silence) |
| coarse_i | input | 3 | Coarse attenuation code, 8 dB per step |
| fine_i | input | 3 | Fine attenuation code, 1 dB per step |
| mute_i | input | 1 | Mute request |
| zc_en_i | input | 1 | 1: gate the write on a zero crossing; 0: apply at once |
| hw_mute_i | input | 1 | Hardware mute, active high |
| out_l_o | output | 16 | Scaled left sample |
| out_r_o | output | 16 | Scaled right sample |
| out_mono_o | output | 16 | Average of left and right outputs |
| zc_stat_o | output | 1 | 1 once the last write has been applied |

## Verification
The hardest case to reach is a gated write that sees one channel cross, is then overwritten, and must ignore that earlier crossing. A stray crossing would commit it early. The bench holds every selected sample at a constant sign, so no crossing happens by accident. It then flips the sign of the left and right channels in separately timed steps around the writes. This shows that commit waits for both channels and that a rewrite restarts the wait.

// File: rtl/zcv_pkg.sv
package zcv_pkg;
  localparam int unsigned CODE_W   = 3;
  localparam int unsigned GAIN_W   = 16;
  localparam int unsigned UNITY    = 32767;
  localparam int unsigned STEP_MUL = 29205;  // 1 dB step in Q0.15

  typedef struct packed {
    logic [CODE_W-1:0] coarse;
    logic [CODE_W-1:0] fine;
    logic              mute;
  } vol_cfg_t;

  function automatic logic [GAIN_W-1:0] gain_at(int unsigned db);
    int unsigned g;
    g = UNITY;
    for (int unsigned i = 0; i < db; i++) g = (g * STEP_MUL) >> 15;
    return g[GAIN_W-1:0];
  endfunction
endpackage

// File: rtl/zcv_gain_rom.sv
module zcv_gain_rom #(
  parameter int unsigned IDX_W  = 6,
  parameter int unsigned GAIN_W = 16
) (
  input  logic [IDX_W-1:0]  idx_i,
  output logic [GAIN_W-1:0] gain_o
);
  localparam int unsigned N_STEPS = 2 ** IDX_W;
  logic [GAIN_W-1:0] tbl [N_STEPS];

  for (genvar i = 0; i < N_STEPS; i++) begin : g_tbl
    assign tbl[i] = zcv_pkg::gain_at(i);
  end

  assign gain_o = tbl[idx_i];
endmodule

// File: rtl/zcv_zc_detect.sv
module zcv_zc_detect #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] smp_i,
  output logic         zc_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= smp_i;
  end

  assign zc_o = (smp_i == '0) || (smp_i[W-1] != prev_q[W-1]);
endmodule

// File: rtl/zcv_atten_mul.sv
module zcv_atten_mul #(
  parameter int unsigned W  = 16,
  parameter int unsigned GW = 16
) (
  input  logic [W-1:0]  smp_i,
  input  logic [GW-1:0] gain_i,
  output logic [W-1:0]  res_o
);
  localparam int unsigned PW = W + GW + 1;

  logic signed [PW-1:0] prod, shf, hi, lo;

  assign hi   = {{(GW+1){1'b0}}, 1'b0, {(W-1){1'b1}}};
  assign lo   = {{(GW+1){1'b1}}, 1'b1, {(W-1){1'b0}}};
  assign prod = $signed(smp_i) * $signed({1'b0, gain_i});
  assign shf  = prod >>> (GW - 1);

  always_comb begin
    if (shf > hi)      res_o = hi[W-1:0];
    else if (shf < lo) res_o = lo[W-1:0];
    else               res_o = shf[W-1:0];
  end

  function automatic logic [W:0] mag(logic [W-1:0] v);
    logic signed [W:0] s;
    s = $signed({v[W-1], v});
    return (s < 0) ? -s : s;
  endfunction

  always_comb begin
    AST_NO_GROWTH: assert (mag(res_o) <= mag(smp_i)); // R2
  end
endmodule

// File: rtl/zc_volume_ctrl.sv
module zc_volume_ctrl #(
  parameter int unsigned W     = 16,
  parameter int unsigned N_SRC = 5,
  parameter int unsigned SEL_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_SRC*W-1:0] src_l_i,
  input  logic [N_SRC*W-1:0] src_r_i,
  input  logic               wr_i,
  input  logic [SEL_W-1:0]   src_sel_i,
  input  logic [2:0]         coarse_i,
  input  logic [2:0]         fine_i,
  input  logic               mute_i,
  input  logic               zc_en_i,
  input  logic               hw_mute_i,
  output logic [W-1:0]       out_l_o,
  output logic [W-1:0]       out_r_o,
  output logic [W-1:0]       out_mono_o,
  output logic               zc_stat_o
);
  import zcv_pkg::*;

  localparam int unsigned N_CH  = 2;
  localparam int unsigned ATT_W = 2 * CODE_W;

  vol_cfg_t          act_q, pnd_q, wr_cfg;
  logic [SEL_W-1:0]  src_q;
  logic              pend_q, stat_q;
  logic [N_CH-1:0]   crossed_q, zc;
  logic              commit;
  logic [ATT_W-1:0]  att_idx;
  logic [GAIN_W-1:0] gain;
  logic [N_CH-1:0][N_SRC*W-1:0] bus;
  logic [N_CH-1:0][W-1:0]       out_q;

  assign bus[0] = src_l_i;
  assign bus[1] = src_r_i;
  assign wr_cfg = '{coarse: coarse_i, fine: fine_i, mute: mute_i};

  // coarse*8 + fine is the plain concatenation
  assign att_idx = {act_q.coarse, act_q.fine};

  zcv_gain_rom #(.IDX_W(ATT_W), .GAIN_W(GAIN_W)) u_rom (
    .idx_i(att_idx), .gain_o(gain)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic [W-1:0] sel, s1_q, att;

    always_comb begin
      sel = '0;
      for (int k = 0; k < N_SRC; k++)
        if (src_q == SEL_W'(k)) sel = bus[c][k*W +: W];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q     <= '0;
        out_q[c] <= '0;
      end else begin
        s1_q     <= sel;
        out_q[c] <= (act_q.mute || hw_mute_i) ? '0 : att;
      end
    end

    zcv_zc_detect #(.W(W)) u_zc (
      .clk_i, .rst_ni, .smp_i(s1_q), .zc_o(zc[c])
    );

    zcv_atten_mul #(.W(W), .GW(GAIN_W)) u_mul (
      .smp_i(s1_q), .gain_i(gain), .res_o(att)
    );
  end

  assign commit = pend_q && (&(crossed_q | zc));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q     <= '0;
      pnd_q     <= '0;
      src_q     <= '0;
      pend_q    <= 1'b0;
      stat_q    <= 1'b0;
      crossed_q <= '0;
    end else if (wr_i) begin
      src_q     <= src_sel_i;
      crossed_q <= '0;
      if (zc_en_i) begin
        pnd_q  <= wr_cfg;
        pend_q <= 1'b1;
        stat_q <= 1'b0;
      end else begin
        act_q  <= wr_cfg;
        pend_q <= 1'b0;
        stat_q <= 1'b1;
      end
    end else if (commit) begin
      act_q  <= pnd_q;
      pend_q <= 1'b0;
      stat_q <= 1'b1;
    end else if (pend_q) begin
      crossed_q <= crossed_q | zc;
    end
  end

  logic signed [W:0] sum;
  assign sum        = $signed({out_q[0][W-1], out_q[0]}) + $signed({out_q[1][W-1], out_q[1]});
  assign out_mono_o = sum[W:1];
  assign out_l_o    = out_q[0];
  assign out_r_o    = out_q[1];
  assign zc_stat_o  = stat_q;

  AST_IMM_APPLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !zc_en_i |=> zc_stat_o && !pend_q); // R4
  AST_GATED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && zc_en_i |=> !zc_stat_o && pend_q); // R5
  AST_STAT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i && !pend_q |=> $stable(zc_stat_o)); // R6
  AST_HW_SILENCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_mute_i |=> out_l_o == '0 && out_r_o == '0 && out_mono_o == '0); // R8
  AST_SRC_SILENCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_q >= SEL_W'(N_SRC)) && $past(src_q >= SEL_W'(N_SRC)) && !wr_i
      |=> out_l_o == '0 && out_r_o == '0); // R3
endmodule

// File: tb/zc_volume_ctrl_test.sv
module zc_volume_ctrl_test;
  localparam int W = 16;
  localparam int NS = 5;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [NS*W-1:0] src_l, src_r;
  logic wr = 0, mute = 0, zc_en = 0, hw_mute = 0;
  logic [2:0] sel = 0, coarse = 0, fine = 0;
  logic [W-1:0] out_l, out_r, out_m;
  logic stat;
  logic signed [W-1:0] lv [NS];
  logic signed [W-1:0] rv [NS];
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  always_comb
    for (int k = 0; k < NS; k++) begin
      src_l[k*W +: W] = lv[k];
      src_r[k*W +: W] = rv[k];
    end

  zc_volume_ctrl uut (
    .clk_i(clk), .rst_ni, .src_l_i(src_l), .src_r_i(src_r), .wr_i(wr),
    .src_sel_i(sel), .coarse_i(coarse), .fine_i(fine), .mute_i(mute),
    .zc_en_i(zc_en), .hw_mute_i(hw_mute), .out_l_o(out_l), .out_r_o(out_r),
    .out_mono_o(out_m), .zc_stat_o(stat)
  );

  function automatic int gain_b(int db);
    int g = 32767;
    for (int i = 0; i < db; i++) g = (g * 29205) / 32768;
    return g;
  endfunction

  function automatic int exp_att(int s, int db);
    longint p = longint'(s) * gain_b(db);
    p = p >>> 15;
    if (p > 32767) p = 32767;
    if (p < -32768) p = -32768;
    return int'(p);
  endfunction

  task automatic chk(string req, int act, int expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic int sx(logic [W-1:0] v);
    return int'($signed(v));
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_cfg(int db, bit m, bit z, int s);
    coarse = 3'(db / 8); fine = 3'(db % 8); mute = m; zc_en = z; sel = 3'(s);
    wr = 1; tick(1); wr = 0;
  endtask

  task automatic set0(int l, int r);
    lv[0] = 16'(l); rv[0] = 16'(r);
  endtask

  initial begin
    for (int k = 0; k < NS; k++) begin lv[k] = 0; rv[k] = 0; end
    tick(2);
    chk("R1 left", sx(out_l), 0);
    chk("R1 stat", int'(stat), 0);
    rst_ni = 1;
    set0(10000, -4000);
    tick(3);
    chk("R1 default left", sx(out_l), exp_att(10000, 0));
    chk("R1 default right", sx(out_r), exp_att(-4000, 0));

    // R2 / R4 / R9 sweep of all attenuation codes
    for (int db = 0; db < 64; db++) begin
      int vals [4] = '{12345, -12345, 32767, -32768};
      for (int v = 0; v < 4; v++) begin
        int l = vals[v], r = vals[v] / 3;
        set0(l, r);
        wr_cfg(db, 0, 0, 0);
        tick(3);
        chk("R2 left", sx(out_l), exp_att(l, db));
        chk("R2 right", sx(out_r), exp_att(r, db));
        chk("R9 mono", sx(out_m), (exp_att(l, db) + exp_att(r, db)) >>> 1);
        chk("R4 stat", int'(stat), 1);
      end
    end

    // R3 source codes
    for (int k = 0; k < NS; k++) begin lv[k] = 16'(1000 * (k + 1)); rv[k] = 16'(-500 * (k + 1)); end
    for (int c = 0; c < 8; c++) begin
      wr_cfg(0, 0, 0, c);
      tick(3);
      chk("R3 left", sx(out_l), c < NS ? exp_att(1000 * (c + 1), 0) : 0);
      chk("R3 right", sx(out_r), c < NS ? exp_att(-500 * (c + 1), 0) : 0);
    end

    // R5 / R6 gated volume
    set0(8000, 8000);
    wr_cfg(0, 0, 0, 0); tick(3);
    wr_cfg(8, 0, 1, 0); tick(5);
    chk("R5 stat", int'(stat), 0);
    chk("R5 old volume", sx(out_l), exp_att(8000, 0));
    set0(-8000, 8000); tick(5);
    chk("R6 one channel", sx(out_l), exp_att(-8000, 0));
    chk("R6 stat one channel", int'(stat), 0);
    set0(-8000, -8000); tick(5);
    chk("R6 commit left", sx(out_l), exp_att(-8000, 8));
    chk("R6 commit right", sx(out_r), exp_att(-8000, 8));
    chk("R6 stat", int'(stat), 1);

    // R7 gated mute and un-mute
    wr_cfg(8, 1, 1, 0); tick(5);
    chk("R7 mute pending", sx(out_l), exp_att(-8000, 8));
    set0(8000, 8000); tick(5);
    chk("R7 muted", sx(out_l), 0);
    chk("R7 muted mono", sx(out_m), 0);
    chk("R7 stat", int'(stat), 1);
    wr_cfg(2, 0, 1, 0); tick(5);
    chk("R7 unmute pending", sx(out_r), 0);
    set0(0, -8000); tick(5);
    chk("R7 unmuted right", sx(out_r), exp_att(-8000, 2));
    chk("R7 unmuted left", sx(out_l), 0);

    // R10 rewrite restarts tracking
    set0(5000, 5000); tick(5);
    wr_cfg(3, 0, 1, 0); tick(2);
    set0(-5000, 5000); tick(3);
    wr_cfg(5, 0, 1, 0); tick(2);
    set0(-5000, -5000); tick(4);
    chk("R10 no early commit", sx(out_r), exp_att(-5000, 2));
    chk("R10 stat", int'(stat), 0);
    set0(5000, -5000); tick(4);
    chk("R10 new setting left", sx(out_l), exp_att(5000, 5));
    chk("R10 new setting right", sx(out_r), exp_att(-5000, 5));

    // R8 hardware mute
    set0(7000, -3000);
    wr_cfg(0, 0, 0, 0); tick(3);
    hw_mute = 1; tick(3);
    chk("R8 left", sx(out_l), 0);
    chk("R8 right", sx(out_r), 0);
    chk("R8 mono", sx(out_m), 0);
    hw_mute = 0; tick(3);
    chk("R8 resume left", sx(out_l), exp_att(7000, 0));
    chk("R9 resume mono", sx(out_m), (exp_att(7000, 0) + exp_att(-3000, 0)) >>> 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule